// File: doc/BRIEF.md
# Two-Sided Doorbell Mailbox

This block lets two register-bus agents, called side A and side B, exchange short messages in both directions. Each direction owns a bank of sixteen 32-bit data words. The sending side fills its outgoing bank, then posts the message with a single write to a shared status/control word. That write raises a pending flag and records a header count and a byte count. The receiving side reads the words from its incoming window. It then clears the pending flag and counts by writing ones to them, and it raises a completion or acknowledge flag that the sender clears in the same way.

Side A also has an interrupt register with three sources, a pair of enable registers (one to set enables and one to clear them), and an error-status register. The error-status register latches access faults: illegal operations, writes to a full outbox, reads of an empty inbox, and an injected parity fault together with the address of the failing access. Both sides use the same synchronous port: an address, write data, a write strobe and a read strobe. Read data appears on the cycle after the read strobe.

Top module: `dbmbox_top`

## Requirements
- R1: After a synchronous reset, the status/control word, interrupt register, enable register and error register all read zero, and `irq_a` is low.
- R2: Words that side A writes at offsets 0x40-0x4F can be read by side B at 0x80-0x8F, and words that side B writes at 0x40-0x4F can be read by side A at 0x80-0x8F. Read data is valid on the cycle after the read strobe.
- R3: The status/control word is at offset 0x00. Side A posts by writing it with bit 29 set, and side B posts by writing it with bit 28 set. If the poster's direction is idle, the write sets that pending bit and loads the header count and the byte count: bits 23:20 and 19:12 for side A, bits 11:8 and 7:0 for side B. The pending bit stays set until the other side clears it.
- R4: A post from side A while bit 29 is set, or while bits 23:12 are nonzero, leaves those fields unchanged and sets the write-while-full error (error bit 1).
- R5: A posted byte count above 64 (sixteen words) is stored as 64. On side A this also sets the illegal-operation error (error bit 0).
- R6: Side A writing ones clears bit 28, bits 11:0 and acknowledge bit 25, and a one in bit 26 sets done bit 26. Side B writing ones clears bit 29, bits 23:12 and done bit 26, and a one in bit 25 sets acknowledge bit 25. Set takes priority over clear.
- R7: Bits 31 (permission to send) and 30 (abort) are plain read/write from side A. A write of all zeros clears them and leaves any pending message in place.
- R8: The interrupt register is at offset 0x01. Bit 0 is set when side B posts, bit 1 when side B sets the acknowledge bit, and bit 2 whenever any error is latched. Writing ones from side A clears those bits.
- R9: A write to offset 0x02 sets the enable bits given as ones, and a write to offset 0x03 clears them. Both offsets read back the enables. `irq_a` is high exactly when some interrupt bit and its enable are both set.
- R10: The error register is at offset 0x04. Bit 0 (illegal) is set by a side-A access to an unmapped offset or a write to 0x80-0x8F. Bit 1 (full) is set by a data write at 0x40-0x4F while bit 29 is set, and that data write is dropped. Bit 2 (empty) is set by a read at 0x80-0x8F while bit 28 is clear. Writing a one to bit 16 clears the register.
- R11: If `par_inject` is high during a side-A access, error bit 3 is set and the 8-bit access address is stored in error bits 23:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_addr | input | 8 | Side A word offset |
| a_wdata | input | 32 | Side A write data |
| a_we | input | 1 | Side A write strobe |
| a_re | input | 1 | Side A read strobe |
| a_rdata | output | 32 | Side A read data, one cycle after a_re |
| b_addr | input | 8 | Side B word offset |
| b_wdata | input | 32 | Side B write data |
| b_we | input | 1 | Side B write strobe |
| b_re | input | 1 | Side B read strobe |
| b_rdata | output | 32 | Side B read data, one cycle after b_re |
| par_inject | input | 1 | Parity-fault injection, sampled during side-A accesses |
| irq_a | output | 1 | Side A interrupt request |

## Verification
Some rules are checked by the assertions on every cycle. A posted pending flag holds until the peer writes it clear, a refused post leaves side A's counts untouched, and stored byte counts never exceed the cap. The acknowledge bit can only rise after a side-B write, the permission and abort bits follow side A's last write, and a newly latched error always raises the doorbell-error interrupt. Other behaviour can only be shown by the bench's scenarios, because it depends on data paths and on the order of events. This covers data moving through both banks, a dropped write into a pending outbox, the full two-way handshake, saturation, the error causes with the captured parity address, and masking of the interrupt output.

// File: rtl/dbmbox_pkg.sv
package dbmbox_pkg;

  // status/control word bit positions
  localparam int ST_PERM  = 31;
  localparam int ST_ABORT = 30;
  localparam int ST_APEND = 29;
  localparam int ST_BPEND = 28;
  localparam int ST_XDN   = 26;
  localparam int ST_XUP   = 25;
  localparam int A_HDR_LO = 20;
  localparam int A_CNT_LO = 12;
  localparam int B_HDR_LO = 8;
  localparam int B_CNT_LO = 0;
  localparam int HDR_W    = 4;
  localparam int CNT_W    = 8;

  // interrupt sources
  localparam int INT_N     = 3;
  localparam int INT_DPEND = 0;
  localparam int INT_ACK   = 1;
  localparam int INT_DBERR = 2;

  // error register
  localparam int ERR_N     = 4;
  localparam int ERR_ILL   = 0;
  localparam int ERR_FULL  = 1;
  localparam int ERR_EMPTY = 2;
  localparam int ERR_PAR   = 3;
  localparam int ERR_AD_LO = 16;
  localparam int ERR_CLR   = 16;

  typedef enum logic [2:0] {
    K_STAT, K_INT, K_MSET, K_MCLR, K_ERR, K_OUT, K_IN, K_NONE
  } akind_t;

  function automatic akind_t classify(input logic [7:0] a, input int words);
    akind_t k;
    k = K_NONE;
    if (a[7:6] == 2'b01 && 32'(a[5:0]) < words) k = K_OUT;
    else if (a[7:6] == 2'b10 && 32'(a[5:0]) < words) k = K_IN;
    else begin
      case (a)
        8'h00:   k = K_STAT;
        8'h01:   k = K_INT;
        8'h02:   k = K_MSET;
        8'h03:   k = K_MCLR;
        8'h04:   k = K_ERR;
        default: k = K_NONE;
      endcase
    end
    return k;
  endfunction

endpackage

// File: rtl/dbmbox_bank.sv
module dbmbox_bank #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 16,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [WORDS];

  // single write port, registered read with enable: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dbmbox_ctrl.sv
module dbmbox_ctrl
  import dbmbox_pkg::*;
#(
  parameter int MAX_BYTES = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        a_wr,
  input  logic [31:0] a_wd,
  input  logic        b_wr,
  input  logic [31:0] b_wd,
  output logic [31:0] stat_q,
  output logic        a_refused,
  output logic        a_sat,
  output logic        b_posted,
  output logic        b_ack
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_BYTES);
  localparam logic [31:0] A_CLR_MASK = (32'd1 << ST_BPEND) | (32'd1 << ST_XUP) | 32'h0000_0FFF;
  localparam logic [31:0] B_CLR_MASK = (32'd1 << ST_APEND) | (32'd1 << ST_XDN) | 32'h00FF_F000;

  function automatic logic [CNT_W-1:0] clamp(input logic [CNT_W-1:0] c);
    return (c > CAP) ? CAP : c;
  endfunction

  logic        a_busy, b_busy, a_ok, b_ok;
  logic [31:0] a_set, a_clr, b_set, b_clr, nxt;

  always_comb begin
    a_busy = stat_q[ST_APEND] | (|stat_q[A_HDR_LO+HDR_W-1:A_CNT_LO]);
    b_busy = stat_q[ST_BPEND] | (|stat_q[B_HDR_LO+HDR_W-1:B_CNT_LO]);

    a_ok      = a_wr & a_wd[ST_APEND] & ~a_busy;
    a_refused = a_wr & a_wd[ST_APEND] & a_busy;
    a_sat     = a_ok & (a_wd[A_CNT_LO +: CNT_W] > CAP);
    b_ok      = b_wr & b_wd[ST_BPEND] & ~b_busy;

    a_set = '0;
    if (a_ok) begin
      a_set[ST_APEND]              = 1'b1;
      a_set[A_HDR_LO +: HDR_W]     = a_wd[A_HDR_LO +: HDR_W];
      a_set[A_CNT_LO +: CNT_W]     = clamp(a_wd[A_CNT_LO +: CNT_W]);
    end
    if (a_wr && a_wd[ST_XDN]) a_set[ST_XDN] = 1'b1;
    a_clr = a_wr ? (a_wd & A_CLR_MASK) : '0;

    b_set = '0;
    if (b_ok) begin
      b_set[ST_BPEND]              = 1'b1;
      b_set[B_HDR_LO +: HDR_W]     = b_wd[B_HDR_LO +: HDR_W];
      b_set[B_CNT_LO +: CNT_W]     = clamp(b_wd[B_CNT_LO +: CNT_W]);
    end
    if (b_wr && b_wd[ST_XUP]) b_set[ST_XUP] = 1'b1;
    b_clr = b_wr ? (b_wd & B_CLR_MASK) : '0;

    // clears act on the old state, sets win
    nxt = (stat_q & ~(a_clr | b_clr)) | a_set | b_set;
    if (a_wr) nxt[ST_PERM:ST_ABORT] = a_wd[ST_PERM:ST_ABORT];

    b_posted = b_ok;
    b_ack    = b_wr & b_wd[ST_XUP];
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= nxt;
  end
endmodule

// File: rtl/dbmbox_irqerr.sv
module dbmbox_irqerr
  import dbmbox_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_int,
  input  logic             wr_mset,
  input  logic             wr_mclr,
  input  logic             wr_err,
  input  logic [INT_N-1:0] wd_lo,
  input  logic             wd_clr,
  input  logic             ev_dpend,
  input  logic             ev_ack,
  input  logic [ERR_N-1:0] ev_err,
  input  logic [7:0]       par_addr,
  output logic [INT_N-1:0] int_q,
  output logic [INT_N-1:0] en_q,
  output logic [31:0]      err_q,
  output logic             irq
);
  logic [INT_N-1:0] int_set, int_nxt, en_nxt;
  logic [31:0]      err_nxt;

  always_comb begin
    int_set            = '0;
    int_set[INT_DPEND] = ev_dpend;
    int_set[INT_ACK]   = ev_ack;
    int_set[INT_DBERR] = |ev_err;
    int_nxt = (int_q & ~(wr_int ? wd_lo : '0)) | int_set;

    en_nxt = en_q;
    if (wr_mset) en_nxt = en_q | wd_lo;
    if (wr_mclr) en_nxt = en_q & ~wd_lo;

    err_nxt = (wr_err && wd_clr) ? '0 : err_q;
    err_nxt[ERR_N-1:0] = err_nxt[ERR_N-1:0] | ev_err;
    if (ev_err[ERR_PAR]) err_nxt[ERR_AD_LO +: 8] = par_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      int_q <= '0;
      en_q  <= '0;
      err_q <= '0;
    end else begin
      int_q <= int_nxt;
      en_q  <= en_nxt;
      err_q <= err_nxt;
    end
  end

  assign irq = |(int_q & en_q);
endmodule

// File: rtl/dbmbox_top.sv
module dbmbox_top
  import dbmbox_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WORDS  = 16,
  localparam int IDX_W = $clog2(WORDS),
  localparam int MAX_BYTES = WORDS * DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  input  logic              a_we,
  input  logic              a_re,
  output logic [DATA_W-1:0] a_rdata,
  input  logic [7:0]        b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  input  logic              b_we,
  input  logic              b_re,
  output logic [DATA_W-1:0] b_rdata,
  input  logic              par_inject,
  output logic              irq_a
);
  akind_t a_kind, b_kind;
  logic [31:0] stat_q, err_q;
  logic [INT_N-1:0] int_q, en_q;
  logic a_refused, a_sat, b_posted, b_ack;
  logic [ERR_N-1:0] ev_err;
  logic ab_we, ba_we;
  logic [DATA_W-1:0] ab_q, ba_q, a_reg_q, b_reg_q, a_mux;
  logic a_sel_q, b_sel_q, a_acc;

  assign a_kind = classify(a_addr, WORDS);
  assign b_kind = classify(b_addr, WORDS);
  assign a_acc  = a_we | a_re;

  dbmbox_ctrl #(.MAX_BYTES(MAX_BYTES)) u_ctrl (
    .clk(clk), .rst(rst),
    .a_wr(a_we && a_kind == K_STAT), .a_wd(a_wdata),
    .b_wr(b_we && b_kind == K_STAT), .b_wd(b_wdata),
    .stat_q(stat_q), .a_refused(a_refused), .a_sat(a_sat),
    .b_posted(b_posted), .b_ack(b_ack)
  );

  // outgoing bank of each side is the incoming bank of the other
  assign ab_we = a_we && a_kind == K_OUT && !stat_q[ST_APEND];
  assign ba_we = b_we && b_kind == K_OUT && !stat_q[ST_BPEND];

  dbmbox_bank #(.DATA_W(DATA_W), .WORDS(WORDS)) u_bank_ab (
    .clk(clk), .we(ab_we), .waddr(a_addr[IDX_W-1:0]), .wdata(a_wdata),
    .re(b_re && b_kind == K_IN), .raddr(b_addr[IDX_W-1:0]), .rdata(ab_q)
  );

  dbmbox_bank #(.DATA_W(DATA_W), .WORDS(WORDS)) u_bank_ba (
    .clk(clk), .we(ba_we), .waddr(b_addr[IDX_W-1:0]), .wdata(b_wdata),
    .re(a_re && a_kind == K_IN), .raddr(a_addr[IDX_W-1:0]), .rdata(ba_q)
  );

  always_comb begin
    ev_err            = '0;
    ev_err[ERR_ILL]   = (a_acc && a_kind == K_NONE) || (a_we && a_kind == K_IN) || a_sat;
    ev_err[ERR_FULL]  = a_refused || (a_we && a_kind == K_OUT && stat_q[ST_APEND]);
    ev_err[ERR_EMPTY] = a_re && a_kind == K_IN && !stat_q[ST_BPEND];
    ev_err[ERR_PAR]   = par_inject && a_acc;
  end

  dbmbox_irqerr u_irqerr (
    .clk(clk), .rst(rst),
    .wr_int (a_we && a_kind == K_INT),
    .wr_mset(a_we && a_kind == K_MSET),
    .wr_mclr(a_we && a_kind == K_MCLR),
    .wr_err (a_we && a_kind == K_ERR),
    .wd_lo(a_wdata[INT_N-1:0]), .wd_clr(a_wdata[ERR_CLR]),
    .ev_dpend(b_posted), .ev_ack(b_ack), .ev_err(ev_err), .par_addr(a_addr),
    .int_q(int_q), .en_q(en_q), .err_q(err_q), .irq(irq_a)
  );

  always_comb begin
    case (a_kind)
      K_STAT:         a_mux = stat_q;
      K_INT:          a_mux = DATA_W'(int_q);
      K_MSET, K_MCLR: a_mux = DATA_W'(en_q);
      K_ERR:          a_mux = err_q;
      default:        a_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_reg_q <= '0; a_sel_q <= 1'b0;
      b_reg_q <= '0; b_sel_q <= 1'b0;
    end else begin
      if (a_re) begin
        a_reg_q <= a_mux;
        a_sel_q <= (a_kind == K_IN);
      end
      if (b_re) begin
        b_reg_q <= (b_kind == K_STAT) ? stat_q : '0;
        b_sel_q <= (b_kind == K_IN);
      end
    end
  end

  assign a_rdata = a_sel_q ? ba_q : a_reg_q;
  assign b_rdata = b_sel_q ? ab_q : b_reg_q;
endmodule

// File: rtl/dbmbox_chk.sv
module dbmbox_chk
  import dbmbox_pkg::*;
#(
  parameter int MAX_BYTES = 64
) (
  input logic             clk,
  input logic             rst,
  input logic [7:0]       a_addr,
  input logic [2:0]       a_wd_top,
  input logic             a_we,
  input logic [7:0]       b_addr,
  input logic             b_wd_apend,
  input logic             b_wd_xup,
  input logic             b_we,
  input logic [1:0]       st_ctl,
  input logic             st_apend,
  input logic             st_xup,
  input logic [11:0]      st_afields,
  input logic [7:0]       st_bcnt,
  input logic [INT_N-1:0] int_q,
  input logic [ERR_N-1:0] err_lo,
  input logic             irq_a
);
  localparam logic [7:0] CAP = 8'(MAX_BYTES);

  AST_APEND_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (st_apend && !(b_we && b_addr == 8'h00 && b_wd_apend)) |=> st_apend); // R3

  AST_REFUSE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (a_we && a_addr == 8'h00 && a_wd_top[0] && st_apend && !(b_we && b_addr == 8'h00))
    |=> $stable(st_afields)); // R4

  AST_COUNT_CAP: assert property (@(posedge clk) disable iff (rst)
    (st_afields[7:0] <= CAP) && (st_bcnt <= CAP)); // R5

  AST_XUP_FROM_B: assert property (@(posedge clk) disable iff (rst)
    $rose(st_xup) |-> $past(b_we && b_addr == 8'h00 && b_wd_xup)); // R6

  AST_CTL_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (a_we && a_addr == 8'h00) |=> st_ctl == $past(a_wd_top[2:1])); // R7

  AST_ERR_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
    $rose(|err_lo) |-> int_q[INT_DBERR]); // R8

  AST_IRQ_NEEDS_SRC: assert property (@(posedge clk) disable iff (rst)
    irq_a |-> (|int_q)); // R9
endmodule

bind dbmbox_top dbmbox_chk #(.MAX_BYTES(MAX_BYTES)) u_chk (
  .clk(clk), .rst(rst),
  .a_addr(a_addr), .a_wd_top(a_wdata[31:29]), .a_we(a_we),
  .b_addr(b_addr), .b_wd_apend(b_wdata[29]), .b_wd_xup(b_wdata[25]), .b_we(b_we),
  .st_ctl(stat_q[31:30]), .st_apend(stat_q[29]), .st_xup(stat_q[25]),
  .st_afields(stat_q[23:12]), .st_bcnt(stat_q[7:0]),
  .int_q(int_q), .err_lo(err_q[3:0]), .irq_a(irq_a)
);

// File: tb/sim_dbmbox_top.sv
module sim_dbmbox_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  a_addr = '0, b_addr = '0;
  logic [31:0] a_wdata = '0, b_wdata = '0;
  logic        a_we = 1'b0, a_re = 1'b0, b_we = 1'b0, b_re = 1'b0;
  logic        par_inject = 1'b0;
  logic [31:0] a_rdata, b_rdata;
  logic        irq_a;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  dbmbox_top u0 (
    .clk(clk), .rst(rst),
    .a_addr(a_addr), .a_wdata(a_wdata), .a_we(a_we), .a_re(a_re), .a_rdata(a_rdata),
    .b_addr(b_addr), .b_wdata(b_wdata), .b_we(b_we), .b_re(b_re), .b_rdata(b_rdata),
    .par_inject(par_inject), .irq_a(irq_a)
  );

  localparam logic SA = 1'b0, SB = 1'b1;
  localparam logic [1:0] OW = 2'd0, OR = 2'd1, ON = 2'd2, OI = 2'd3;
  localparam logic [31:0] D0 = 32'hA5A5_0001, D1 = 32'h1234_5678, D2 = 32'hDEAD_BEEF;
  localparam logic [31:0] D9 = 32'h9999_9999, E0 = 32'h0BAD_F00D, E1 = 32'hCAFE_0042;

  function automatic logic [50:0] mk(input logic s, input logic [1:0] op,
                                     input logic [7:0] ad, input logic [31:0] d,
                                     input logic [7:0] r);
    return {s, op, ad, d, r};
  endfunction

  localparam int NV = 59;
  localparam logic [50:0] TBL [NV] = '{
    mk(SA, OW, 8'h02, 32'h7, 9),            // R9 enable all
    mk(SA, OR, 8'h02, 32'h7, 9),
    mk(SA, OR, 8'h03, 32'h7, 9),
    mk(SA, OW, 8'h40, D0, 2),               // R2 fill outbox
    mk(SA, OW, 8'h41, D1, 2),
    mk(SA, OW, 8'h42, D2, 2),
    mk(SA, OW, 8'h00, 32'h2010_C000, 3),    // R3 post hdr 1, 12 bytes
    mk(SA, OR, 8'h00, 32'h2010_C000, 3),
    mk(SB, OR, 8'h00, 32'h2010_C000, 3),
    mk(SB, OR, 8'h80, D0, 2),
    mk(SB, OR, 8'h82, D2, 2),
    mk(SA, OW, 8'h40, D9, 10),              // R10 write into pending outbox dropped
    mk(SB, OR, 8'h80, D0, 10),
    mk(SA, OR, 8'h04, 32'h2, 10),
    mk(SA, OR, 8'h01, 32'h4, 8),
    mk(SA, OI, 8'h00, 32'h1, 9),
    mk(SA, OW, 8'h04, 32'h0001_0000, 10),
    mk(SA, OR, 8'h04, 32'h0, 10),
    mk(SA, OW, 8'h01, 32'h4, 8),            // R8 write-one-to-clear
    mk(SA, OR, 8'h01, 32'h0, 8),
    mk(SA, OI, 8'h00, 32'h0, 9),
    mk(SB, OW, 8'h00, 32'h22FF_F000, 6),    // R6 B consumes and acks
    mk(SA, OR, 8'h00, 32'h0200_0000, 6),
    mk(SA, OR, 8'h01, 32'h2, 8),
    mk(SA, OW, 8'h00, 32'h0200_0000, 6),
    mk(SA, OR, 8'h00, 32'h0, 6),
    mk(SA, OW, 8'h01, 32'h2, 8),
    mk(SB, OW, 8'h40, E0, 2),
    mk(SB, OW, 8'h41, E1, 2),
    mk(SB, OW, 8'h00, 32'h1000_0208, 3),    // R3 B posts hdr 2, 8 bytes
    mk(SA, OR, 8'h00, 32'h1000_0208, 3),
    mk(SA, OR, 8'h01, 32'h1, 8),
    mk(SA, OR, 8'h80, E0, 2),
    mk(SA, OR, 8'h81, E1, 2),
    mk(SA, OW, 8'h00, 32'h1400_0FFF, 6),    // R6 A consumes, sets done
    mk(SA, OR, 8'h00, 32'h0400_0000, 6),
    mk(SB, OW, 8'h00, 32'h0400_0000, 6),
    mk(SB, OR, 8'h00, 32'h0, 6),
    mk(SA, OW, 8'h01, 32'h7, 8),
    mk(SA, OW, 8'h00, 32'h2000_4000, 3),
    mk(SA, OW, 8'h00, 32'h2000_8000, 4),    // R4 refused
    mk(SA, OR, 8'h00, 32'h2000_4000, 4),
    mk(SA, OR, 8'h04, 32'h2, 4),
    mk(SA, OW, 8'h04, 32'h0001_0000, 10),
    mk(SB, OW, 8'h00, 32'h20FF_F000, 6),
    mk(SA, OW, 8'h00, 32'h200C_8000, 5),    // R5 200 bytes
    mk(SA, OR, 8'h00, 32'h2004_0000, 5),
    mk(SA, OR, 8'h04, 32'h1, 5),
    mk(SA, OW, 8'h04, 32'h0001_0000, 10),
    mk(SA, ON, 8'h80, 32'h0, 10),           // R10 read of empty inbox
    mk(SA, OR, 8'h04, 32'h4, 10),
    mk(SA, OW, 8'h04, 32'h0001_0000, 10),
    mk(SA, OW, 8'h10, 32'h1, 10),           // R10 unmapped offset
    mk(SA, OR, 8'h04, 32'h1, 10),
    mk(SA, OW, 8'h04, 32'h0001_0000, 10),
    mk(SA, OW, 8'h00, 32'hC000_0000, 7),    // R7 control bits
    mk(SA, OR, 8'h00, 32'hE004_0000, 7),
    mk(SA, OW, 8'h00, 32'h0, 7),
    mk(SA, OR, 8'h00, 32'h2004_0000, 7)
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [7:0] ad, input logic [31:0] d);
    @(negedge clk);
    if (s == SA) begin a_addr = ad; a_wdata = d; a_we = 1'b1; end
    else         begin b_addr = ad; b_wdata = d; b_we = 1'b1; end
    @(negedge clk);
    a_we = 1'b0; b_we = 1'b0;
  endtask

  task automatic rd(input logic s, input logic [7:0] ad, output logic [31:0] v);
    @(negedge clk);
    if (s == SA) begin a_addr = ad; a_re = 1'b1; end
    else         begin b_addr = ad; b_re = 1'b1; end
    @(negedge clk);
    a_re = 1'b0; b_re = 1'b0;
    v = (s == SA) ? a_rdata : b_rdata;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check(irq_a == 1'b0, "R1 irq", {31'b0, irq_a}, 32'h0);
    check(a_rdata == 32'h0, "R1 rdata", a_rdata, 32'h0);
    rd(SA, 8'h00, v); check(v == 32'h0, "R1 status", v, 32'h0);
    rd(SA, 8'h01, v); check(v == 32'h0, "R1 interrupts", v, 32'h0);
    rd(SA, 8'h02, v); check(v == 32'h0, "R1 enables", v, 32'h0);
    rd(SA, 8'h04, v); check(v == 32'h0, "R1 errors", v, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic        s;
      logic [1:0]  op;
      logic [7:0]  ad, rq;
      logic [31:0] d;
      string       tag;
      {s, op, ad, d, rq} = TBL[i];
      tag = $sformatf("R%0d step %0d", rq, i);
      case (op)
        OW: wr(s, ad, d);
        OR: begin rd(s, ad, v); check(v == d, tag, v, d); end
        ON: rd(s, ad, v);
        default: begin
          @(negedge clk);
          check(irq_a == d[0], tag, {31'b0, irq_a}, d);
        end
      endcase
    end

    // R11 parity injection captures the access address
    @(negedge clk);
    a_addr = 8'h03; a_re = 1'b1; par_inject = 1'b1;
    @(negedge clk);
    a_re = 1'b0; par_inject = 1'b0;
    rd(SA, 8'h04, v); check(v == 32'h0003_0008, "R11 parity capture", v, 32'h0003_0008);
    wr(SA, 8'h04, 32'h0001_0000);
    rd(SA, 8'h04, v); check(v == 32'h0, "R10 clear after parity", v, 32'h0);

    // R9 masking: doorbell-error bit is still set from earlier faults
    @(negedge clk);
    check(irq_a == 1'b1, "R9 irq with enable", {31'b0, irq_a}, 32'h1);
    wr(SA, 8'h03, 32'h3);
    check(irq_a == 1'b1, "R9 partial mask keeps irq", {31'b0, irq_a}, 32'h1);
    wr(SA, 8'h03, 32'h4);
    check(irq_a == 1'b0, "R9 masked irq", {31'b0, irq_a}, 32'h0);
    rd(SA, 8'h02, v); check(v == 32'h0, "R9 enables cleared", v, 32'h0);
    rd(SA, 8'h01, v); check(v[2] == 1'b1, "R8 source still latched", v, 32'h4);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule